// File: doc/BRIEF.md
# Programmable Memory Select Decoder

This block turns a 32-bit bus address into one of five memory-select lines. Each select line has its own window, and software sets three things for it: a base address, a power-of-two block size from 1K to 1M bytes, and a write-protect attribute. Selects 0 and 1 lead to the flash array. Selects 2 and 3 both lead to one 48K-byte RAM array. Select 4 leads to a small 1.5K-byte coprocessor RAM. For each access the block returns three things: the one-hot select, the byte offset inside the chosen block, and a flag for a write that hit a protected window.

Accesses come in on a valid/ready handshake and leave through a single registered result stage that is also valid/ready. The upstream side sees back-pressure through `acc_ready`, which is high whenever the result stage is empty or is being drained in that cycle. A stalled result holds every field unchanged until `out_ready` takes it.

The two RAM windows reach the same physical array. A configuration check therefore raises `ram_cfg_err` when their effective bases are an exact multiple of 48K bytes apart, because such a pair would alias the same storage. All windows come out of reset disabled. Each one starts decoding once software sets its enable bit.

Top module: `msel_decoder`

## Requirements
- R1: After reset, every configuration register reads as zero, no window is enabled, `out_valid` is 0, `ram_cfg_err` is 0 and `acc_ready` is 1.
- R2: The register index is `cfg_addr[3:1]` (window 0 to 4), and `cfg_addr[0]` picks the register: 0 for the base register, 1 for the control register. The base register holds base bits [31:10] in the same bit positions. The control register holds enable in bit 0, write protect in bit 1 and the size code in bits [7:4]. All other bits read as zero, and a write takes effect at the next clock edge.
- R3: An enabled window hits when `acc_addr[31:S]` equals its base bits [31:S]. Here S = 10 + the size code, and any code above 10 counts as 10, so the block size is 1K shifted left by the code and never exceeds 1M.
- R4: Base bits below S are ignored when matching, so a misaligned base acts as the base rounded down to the block size. The register still reads back the value written.
- R5: When several windows hit, only the lowest-numbered one asserts its select, and at most one select bit is ever high.
- R6: A write access whose winning window is write-protected sets `out_viol`, and all select bits stay low. A read access to the same window selects it normally.
- R7: `out_offset` equals `acc_addr` modulo the winning window's block size. It is zero when no select is asserted.
- R8: `ram_cfg_err` is 1 exactly when windows 2 and 3 are both enabled and their effective bases differ by a multiple of 48K bytes, including a difference of zero. It is combinational from the register state.
- R9: An access is accepted on a clock edge where `acc_valid` and `acc_ready` are both high. Its result appears with `out_valid` after that edge. While `out_valid` is high and `out_ready` is low, `acc_ready` is low and every result field stays stable.
- R10: An access that hits no enabled window still produces a result: `out_valid` high, all selects low, `out_viol` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 4 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` |
| ram_cfg_err | output | 1 | RAM window pair aliases the 48K array |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access request can be accepted |
| acc_addr | input | 32 | Access byte address |
| acc_write | input | 1 | Access is a write |
| out_valid | output | 1 | Decode result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_sel | output | 5 | One-hot memory select |
| out_offset | output | 20 | Byte offset inside the selected block |
| out_viol | output | 1 | Write to a protected window |

## Verification
On every cycle the assertions check the output invariants: at most one select is high, a violation never carries a select, a miss carries a zero offset, an accepted access always yields a valid result, and a stalled result stays stable. Some behaviours can only be shown by the bench's scenarios, because they depend on what software programmed: the address-to-window mapping for each size code, the rounding down of misaligned bases, the priority winner among overlapping windows, protect versus read access, and the 48K alias check on the RAM pair.

// File: rtl/msel_pkg.sv
package msel_pkg;
  localparam int ADDR_W   = 32;
  localparam int GRAN_LSB = 10;
  localparam int MAX_CODE = 10;
  localparam int OFF_W    = GRAN_LSB + MAX_CODE;

  typedef struct packed {
    logic [ADDR_W-1:GRAN_LSB] base;
    logic [3:0]               szc;
    logic                     wp;
    logic                     en;
  } win_cfg_t;
endpackage

// File: rtl/msel_regs.sv
module msel_regs
  import msel_pkg::*;
#(
  parameter int NWIN = 5,
  parameter int CA_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [CA_W-1:0]           cfg_addr,
  input  logic [ADDR_W-1:0]         cfg_wdata,
  output logic [ADDR_W-1:0]         cfg_rdata,
  output win_cfg_t [NWIN-1:0]       cfg
);
  localparam int IDX_W = CA_W - 1;

  logic [IDX_W-1:0] idx;
  logic             is_ctl;
  assign idx    = cfg_addr[CA_W-1:1];
  assign is_ctl = cfg_addr[0];

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg[i] <= '0;
      end else if (cfg_we && idx == IDX_W'(i)) begin
        if (is_ctl) begin
          cfg[i].en  <= cfg_wdata[0];
          cfg[i].wp  <= cfg_wdata[1];
          cfg[i].szc <= cfg_wdata[7:4];
        end else begin
          cfg[i].base <= cfg_wdata[ADDR_W-1:GRAN_LSB];
        end
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (idx == IDX_W'(i)) begin
        if (is_ctl) cfg_rdata = {24'd0, cfg[i].szc, 2'd0, cfg[i].wp, cfg[i].en};
        else        cfg_rdata = {cfg[i].base, {GRAN_LSB{1'b0}}};
      end
    end
  end
endmodule

// File: rtl/msel_window.sv
module msel_window
  import msel_pkg::*;
(
  input  logic [ADDR_W-1:0]        addr,
  input  win_cfg_t                 cfg,
  output logic                     hit,
  output logic [OFF_W-1:0]         offset,
  output logic [ADDR_W-1:GRAN_LSB] eff_base
);
  logic [3:0]        code;
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] base_full;

  always_comb begin
    code      = (cfg.szc > 4'(MAX_CODE)) ? 4'(MAX_CODE) : cfg.szc;
    mask      = ~((32'd1 << (GRAN_LSB + int'(code))) - 32'd1);
    base_full = {cfg.base, {GRAN_LSB{1'b0}}} & mask;
    hit       = cfg.en && ((addr & mask) == base_full);
    offset    = addr[OFF_W-1:0] & ~mask[OFF_W-1:0];
    eff_base  = base_full[ADDR_W-1:GRAN_LSB];
  end
endmodule

// File: rtl/msel_ramcheck.sv
module msel_ramcheck #(
  parameter int BW     = 22,
  parameter int RAM_KB = 48
) (
  input  logic          en_a,
  input  logic          en_b,
  input  logic [BW-1:0] base_a,
  input  logic [BW-1:0] base_b,
  output logic          conflict
);
  localparam logic [BW-1:0] RAM_UNITS = BW'(RAM_KB);

  logic [BW-1:0] diff;

  always_comb begin
    diff     = (base_a >= base_b) ? (base_a - base_b) : (base_b - base_a);
    conflict = en_a && en_b && ((diff % RAM_UNITS) == '0);
  end
endmodule

// File: rtl/msel_arbiter.sv
module msel_arbiter #(
  parameter int NWIN  = 5,
  parameter int OFF_W = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_valid,
  input  logic                       acc_write,
  input  logic [NWIN-1:0]            hits,
  input  logic [NWIN-1:0]            wp,
  input  logic [NWIN-1:0][OFF_W-1:0] offsets,
  input  logic                       out_ready,
  output logic                       acc_ready,
  output logic                       out_valid,
  output logic [NWIN-1:0]            out_sel,
  output logic [OFF_W-1:0]           out_offset,
  output logic                       out_viol
);
  logic [NWIN-1:0]  win_oh;
  logic             any_hit;
  logic             viol_n;
  logic [NWIN-1:0]  sel_n;
  logic [OFF_W-1:0] off_n;

  always_comb begin
    win_oh  = '0;
    any_hit = 1'b0;
    for (int i = 0; i < NWIN; i++) begin
      if (hits[i] && !any_hit) begin
        win_oh[i] = 1'b1;
        any_hit   = 1'b1;
      end
    end
    viol_n = acc_write && ((win_oh & wp) != '0);
    sel_n  = viol_n ? '0 : win_oh;
    off_n  = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (sel_n[i]) off_n = offsets[i];
    end
  end

  assign acc_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sel    <= '0;
      out_offset <= '0;
      out_viol   <= 1'b0;
    end else if (acc_valid && acc_ready) begin
      out_valid  <= 1'b1;
      out_sel    <= sel_n;
      out_offset <= off_n;
      out_viol   <= viol_n;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/msel_decoder.sv
module msel_decoder
  import msel_pkg::*;
#(
  parameter int NWIN   = 5,
  parameter int RAM_KB = 48,
  parameter int RAM_A  = 2,
  parameter int RAM_B  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              ram_cfg_err,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [31:0]       acc_addr,
  input  logic              acc_write,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NWIN-1:0]   out_sel,
  output logic [OFF_W-1:0]  out_offset,
  output logic              out_viol
);
  localparam int BW = ADDR_W - GRAN_LSB;

  win_cfg_t [NWIN-1:0]            cfg;
  logic [NWIN-1:0]                hits;
  logic [NWIN-1:0]                wp;
  logic [NWIN-1:0][OFF_W-1:0]     offsets;
  logic [NWIN-1:0][BW-1:0]        eff_base;

  msel_regs #(.NWIN(NWIN), .CA_W(4)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg(cfg)
  );

  for (genvar i = 0; i < NWIN; i++) begin : g_dec
    msel_window u_win (
      .addr(acc_addr), .cfg(cfg[i]), .hit(hits[i]),
      .offset(offsets[i]), .eff_base(eff_base[i])
    );
    assign wp[i] = cfg[i].wp;
  end

  msel_ramcheck #(.BW(BW), .RAM_KB(RAM_KB)) u_ramchk (
    .en_a(cfg[RAM_A].en), .en_b(cfg[RAM_B].en),
    .base_a(eff_base[RAM_A]), .base_b(eff_base[RAM_B]),
    .conflict(ram_cfg_err)
  );

  msel_arbiter #(.NWIN(NWIN), .OFF_W(OFF_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .hits(hits), .wp(wp), .offsets(offsets), .out_ready(out_ready),
    .acc_ready(acc_ready), .out_valid(out_valid), .out_sel(out_sel),
    .out_offset(out_offset), .out_viol(out_viol)
  );
endmodule

// File: rtl/msel_checker.sv
module msel_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_viol,
  input logic [4:0]  out_sel,
  input logic [19:0] out_offset
);
  a_r5_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_sel));

  a_r6_viol_no_select: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_viol) |-> (out_sel == 5'd0));

  a_r7_miss_zero_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sel == 5'd0) |-> (out_offset == 20'd0));

  a_r9_accept_yields: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready) |=> out_valid);

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sel)
      && $stable(out_offset) && $stable(out_viol)));

  a_r9_stall_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !acc_ready);
endmodule

bind msel_decoder msel_checker u_chk (.*);

// File: tb/msel_decoder_test.sv
`timescale 1ns/1ps
module msel_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        ram_cfg_err;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [4:0]  out_sel;
  logic [19:0] out_offset;
  logic        out_viol;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  msel_decoder uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1 chk(req, cfg_rdata, exp);
  endtask

  task automatic access(input string req, input logic [31:0] a, input logic w,
                        input logic [4:0] esel, input logic [19:0] eoff, input logic eviol);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_write = w;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    chk({req, " valid"}, {31'd0, out_valid}, 32'd1);
    chk({req, " sel"},   {27'd0, out_sel}, {27'd0, esel});
    chk({req, " off"},   {12'd0, out_offset}, {12'd0, eoff});
    chk({req, " viol"},  {31'd0, out_viol}, {31'd0, eviol});
  endtask

  task automatic t_reset();
    for (int i = 0; i < 10; i++) rd_chk("R1 reg zero", 4'(i), 32'd0);
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 cfg_err", {31'd0, ram_cfg_err}, 32'd0);
    chk("R1 acc_ready", {31'd0, acc_ready}, 32'd1);
    access("R1 disabled miss", 32'h0000_0000, 1'b0, 5'd0, 20'd0, 1'b0);
  endtask

  task automatic t_miss();
    access("R10 miss", 32'h0000_1000, 1'b0, 5'd0, 20'd0, 1'b0);
  endtask

  task automatic t_basic();
    wr(4'd0, 32'h0010_0000);
    wr(4'd1, 32'h0000_0081);
    rd_chk("R2 base readback", 4'd0, 32'h0010_0000);
    rd_chk("R2 ctl readback",  4'd1, 32'h0000_0081);
    wr(4'd1, 32'hFFFF_FF81);
    rd_chk("R2 ctl unused bits", 4'd1, 32'h0000_0081);
    access("R3 hit 256K", 32'h0012_3456, 1'b0, 5'b00001, 20'h23456, 1'b0);
    access("R3 past end", 32'h0014_0000, 1'b0, 5'd0, 20'd0, 1'b0);
  endtask

  task automatic t_misaligned();
    wr(4'd2, 32'h0020_4000);
    wr(4'd3, 32'h0000_0061);
    rd_chk("R4 raw readback", 4'd2, 32'h0020_4000);
    access("R4 rounded base", 32'h0020_0010, 1'b0, 5'b00010, 20'h00010, 1'b0);
    access("R7 offset 64K", 32'h0020_FFFC, 1'b0, 5'b00010, 20'h0FFFC, 1'b0);
  endtask

  task automatic t_priority();
    wr(4'd6, 32'h0010_0000);
    wr(4'd7, 32'h0000_0001);
    access("R5 lowest wins", 32'h0010_0004, 1'b0, 5'b00001, 20'h00004, 1'b0);
    wr(4'd1, 32'h0000_0000);
    access("R5 next wins", 32'h0010_0004, 1'b0, 5'b01000, 20'h00004, 1'b0);
    wr(4'd9, 32'h0000_0FF1);
    access("R3 code clamp 1M", 32'h000F_FFF0, 1'b0, 5'b10000, 20'hFFFF0, 1'b0);
    wr(4'd9, 32'h0000_0000);
  endtask

  task automatic t_protect();
    wr(4'd8, 32'h0030_0000);
    wr(4'd9, 32'h0000_0013);
    access("R6 write blocked", 32'h0030_0100, 1'b1, 5'd0, 20'd0, 1'b1);
    access("R6 read allowed",  32'h0030_0100, 1'b0, 5'b10000, 20'h00100, 1'b0);
  endtask

  task automatic t_ramchk();
    wr(4'd4, 32'h0040_0400);
    wr(4'd5, 32'h0000_0001);
    #1 chk("R8 no alias", {31'd0, ram_cfg_err}, 32'd0);
    wr(4'd4, 32'h0010_C000);
    #1 chk("R8 48K apart", {31'd0, ram_cfg_err}, 32'd1);
    wr(4'd4, 32'h0011_8000);
    #1 chk("R8 96K apart", {31'd0, ram_cfg_err}, 32'd1);
    wr(4'd4, 32'h0010_0000);
    #1 chk("R8 equal", {31'd0, ram_cfg_err}, 32'd1);
    wr(4'd7, 32'h0000_0000);
    #1 chk("R8 one disabled", {31'd0, ram_cfg_err}, 32'd0);
    wr(4'd7, 32'h0000_0001);
    wr(4'd4, 32'h0040_0400);
    #1 chk("R8 restored", {31'd0, ram_cfg_err}, 32'd0);
  endtask

  task automatic t_stall();
    @(negedge clk);
    out_ready = 1'b0;
    acc_valid = 1'b1; acc_addr = 32'h0030_0000; acc_write = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R9 first sel", {27'd0, out_sel}, 32'h10);
    chk("R9 ready low", {31'd0, acc_ready}, 32'd0);
    acc_addr = 32'h0010_0004;
    @(posedge clk);
    @(negedge clk);
    chk("R9 held sel", {27'd0, out_sel}, 32'h10);
    chk("R9 held off", {12'd0, out_offset}, 32'd0);
    chk("R9 held valid", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    chk("R9 second sel", {27'd0, out_sel}, 32'h08);
    chk("R9 second off", {12'd0, out_offset}, 32'd4);
    @(posedge clk);
    @(negedge clk);
    chk("R9 drained", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    #20000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_miss();
    t_basic();
    t_misaligned();
    t_priority();
    t_protect();
    t_ramchk();
    t_stall();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule